// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add Core

This block evaluates `addend + a * b` in single precision with exactly one rounding step at the end. A front-end that has already dealt with NaN, infinity and zero operands hands over normalized 24-bit significands (leading one at bit 23), two's-complement unbiased exponents, a sign for the product and a sign for the addend, and a flag that marks the addend as zero. The value of an operand is `man / 2^23 * 2^exp`.

The core forms the full 48-bit product with no rounding, places it in a 64-bit working window with its leading one at bit 62, and aligns the smaller operand with a sticky right shift. It then adds or subtracts the two magnitudes and renormalizes. The 64-bit result is cut down to 27 bits (24 significand bits plus guard, round and sticky) by a sticky shift. That value is rounded under one of four modes and packed into an IEEE single word with overflow, underflow and inexact flags.

Operations enter and leave through a valid/ready handshake. One output register separates the two sides, so a result appears one cycle after it is accepted.

Top module: `fma_sp_core`

## Requirements
- R1: An operation is taken when `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` at the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and flags hold steady.
- R2: While `rst_n` is low, `out_valid` is low, and it remains low after reset until an operation is accepted.
- R3: When `addend_zero` is high, the result is the product `a*b` rounded once. The biased exponent is `a_exp + b_exp + 127`, plus one if the significand product is 2.0 or more, and the result sign is `prod_neg`.
- R4: When `prod_neg` equals `addend_neg`, the magnitudes are added. A sum of 2.0 or more in the aligned scale is renormalized by one place, and the lost bit goes into the sticky bit.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger magnitude and is renormalized left until its leading one is in place.
- R6: An exact cancellation gives a zero with no flags set. The zero is `32'h80000000` in mode 3 and `32'h00000000` in every other mode.
- R7: Bits of the addend or product that the alignment shift pushes out are not lost. They set the sticky bit and so affect the inexact flag and directed rounding.
- R8: `rnd_mode` selects the rounding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.
- R9: If the rounded biased exponent reaches 255, `out_overflow` and `out_inexact` are set. The result is infinity (exponent field `8'hFF`, fraction 0) in mode 0, in mode 2 for a positive sign and in mode 3 for a negative sign. Otherwise it is the largest finite value (`8'hFE`, fraction all ones).
- R10: If the biased exponent before rounding is 0 or less, the significand is shifted right by `1 - exponent` with sticky and rounded as a subnormal. `out_underflow` is set exactly when that value is also inexact. A subnormal that rounds up to `2^-126` is packed with exponent field 1.
- R11: `out_inexact` is set exactly when any discarded bit (guard, round or sticky) was non-zero, or when an overflow occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Core can take an operation |
| a_man | input | 24 | Multiplicand significand, bit 23 set |
| a_exp | input | EW | Multiplicand unbiased exponent, signed |
| b_man | input | 24 | Multiplier significand, bit 23 set |
| b_exp | input | EW | Multiplier unbiased exponent, signed |
| c_man | input | 24 | Addend significand, bit 23 set unless addend is zero |
| c_exp | input | EW | Addend unbiased exponent, signed |
| addend_zero | input | 1 | Addend is zero; its significand and exponent are ignored |
| prod_neg | input | 1 | Sign of the product |
| addend_neg | input | 1 | Sign of the addend |
| rnd_mode | input | 2 | Rounding mode (R8) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | IEEE single-precision result |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Every internal fault in this core reaches `out_result` or a flag one cycle after the operation is accepted. No state is carried from one operation to the next, so an error cannot stay hidden and show up later. A wrong alignment or renormalization count moves the exponent field or the fraction by whole bits. A dropped sticky bit shows up only when a directed rounding mode or the inexact flag depends on it, so the directed tests place a tiny addend or a tiny product where only the sticky bit can carry it. A wrong handshake shows up as a result that changes while stalled or as a lost operation.

// File: rtl/fma_sp_core.sv
module fma_sp_core #(
  parameter int EW   = 10,
  parameter int BIAS = 127
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [23:0]          a_man,
  input  logic signed [EW-1:0] a_exp,
  input  logic [23:0]          b_man,
  input  logic signed [EW-1:0] b_exp,
  input  logic [23:0]          c_man,
  input  logic signed [EW-1:0] c_exp,
  input  logic                 addend_zero,
  input  logic                 prod_neg,
  input  logic                 addend_neg,
  input  logic [1:0]           rnd_mode,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_result,
  output logic                 out_overflow,
  output logic                 out_underflow,
  output logic                 out_inexact
);
  localparam int WW   = 64;
  localparam int LEAD = WW - 2;
  localparam int KEEP = 27;
  localparam int CUT  = LEAD - (KEEP - 1);
  localparam int EMAX = 2 * BIAS + 1;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_UP   = 2'd2;
  localparam logic [1:0] RM_DOWN = 2'd3;

  function automatic logic [WW-1:0] shr_w(input logic [WW-1:0] v, input int n);
    logic [WW-1:0] mask;
    if (n <= 0) return v;
    if (n >= WW - 1) return {{(WW-1){1'b0}}, |v};
    mask = ({{(WW-1){1'b0}}, 1'b1} << n) - 1'b1;
    return (v >> n) | {{(WW-1){1'b0}}, |(v & mask)};
  endfunction

  function automatic logic [KEEP-1:0] shr_k(input logic [KEEP-1:0] v, input int n);
    logic [KEEP-1:0] mask;
    if (n <= 0) return v;
    if (n >= KEEP) return {{(KEEP-1){1'b0}}, |v};
    mask = ({{(KEEP-1){1'b0}}, 1'b1} << n) - 1'b1;
    return (v >> n) | {{(KEEP-1){1'b0}}, |(v & mask)};
  endfunction

  logic [47:0]     prod;
  logic [WW-1:0]   pm, cm, m, tmp;
  logic [KEEP-1:0] k;
  logic [24:0]     sig;
  int              pe, ce, e, be, ef, lz;
  logic            s, cancel, tiny, inc, inx, ovf, to_inf;
  logic [31:0]     res;
  logic            res_ovf, res_uf, res_inx;

  assign prod     = a_man * b_man;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    pm = {prod, 16'd0};
    pe = int'(a_exp) + int'(b_exp);
    if (pm[WW-1]) begin
      pm = pm >> 1;
      pe = pe + 1;
    end
    cm     = {1'b0, c_man, 39'd0};
    ce     = int'(c_exp);
    s      = prod_neg;
    e      = pe;
    m      = pm;
    cancel = 1'b0;
    lz     = 0;
    if (!addend_zero) begin
      if (ce > pe) begin
        pm = shr_w(pm, ce - pe);
        e  = ce;
      end else begin
        cm = shr_w(cm, pe - ce);
        e  = pe;
      end
      if (addend_neg == prod_neg) begin
        m = cm + pm;
        if (m[WW-1]) begin
          m = shr_w(m, 1);
          e = e + 1;
        end
      end else begin
        if (cm >= pm) begin
          m = cm - pm;
          s = addend_neg;
        end else begin
          m = pm - cm;
          s = prod_neg;
        end
        if (m == '0) cancel = 1'b1;
        for (int i = 0; i <= LEAD; i++)
          if (m[i]) lz = LEAD - i;
        m = m << lz;
        e = e - lz;
      end
    end

    tmp  = shr_w(m, CUT);
    k    = tmp[KEEP-1:0];
    be   = e + BIAS;
    tiny = (be < 1);
    if (tiny) begin
      k  = shr_k(k, 1 - be);
      be = 0;
    end

    inx = k[2] | k[1] | k[0];
    case (rnd_mode)
      RM_NEAR: inc = k[2] & (k[1] | k[0] | k[3]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = !s & inx;
      default: inc = s & inx;
    endcase
    sig = {1'b0, k[KEEP-1:3]} + {24'd0, inc};

    if (sig[24])   ef = be + 1;
    else if (tiny) ef = sig[23] ? 1 : 0;
    else           ef = be;

    ovf    = (ef >= EMAX);
    to_inf = (rnd_mode == RM_NEAR) || (rnd_mode == RM_UP && !s) || (rnd_mode == RM_DOWN && s);

    if (cancel) begin
      res     = {rnd_mode == RM_DOWN, 31'd0};
      res_ovf = 1'b0;
      res_uf  = 1'b0;
      res_inx = 1'b0;
    end else if (ovf) begin
      res     = to_inf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
      res_ovf = 1'b1;
      res_uf  = 1'b0;
      res_inx = 1'b1;
    end else begin
      res     = {s, 8'(ef), sig[24] ? 23'd0 : sig[22:0]};
      res_ovf = 1'b0;
      res_uf  = tiny & inx;
      res_inx = inx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        out_result    <= res;
        out_overflow  <= res_ovf;
        out_underflow <= res_uf;
        out_inexact   <= res_inx;
      end
    end
  end
endmodule

module fma_sp_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_overflow,
  input logic        out_underflow,
  input logic        out_inexact
);
  p_reset_r2: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_inexact)));

  p_ovf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_inexact && out_result[30:23] >= 8'hFE));

  p_uf_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_inexact && !out_overflow && out_result[30:24] == 7'd0));
endmodule

bind fma_sp_core fma_sp_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_overflow(out_overflow), .out_underflow(out_underflow), .out_inexact(out_inexact)
);

// File: tb/test_fma_sp_core.sv
module test_fma_sp_core;
  localparam int EW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [23:0] a_man = 24'h800000, b_man = 24'h800000, c_man = 24'h800000;
  logic signed [EW-1:0] a_exp = '0, b_exp = '0, c_exp = '0;
  logic addend_zero = 1'b1, prod_neg = 1'b0, addend_neg = 1'b0;
  logic [1:0] rnd_mode = 2'd0;
  logic [31:0] out_result;
  logic out_overflow, out_underflow, out_inexact;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fma_sp_core #(.EW(EW)) i_fma_sp_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_man(a_man), .a_exp(a_exp), .b_man(b_man), .b_exp(b_exp),
    .c_man(c_man), .c_exp(c_exp), .addend_zero(addend_zero),
    .prod_neg(prod_neg), .addend_neg(addend_neg), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_overflow(out_overflow), .out_underflow(out_underflow), .out_inexact(out_inexact)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic set_op(input logic [23:0] am, input int ae, input logic [23:0] bm, input int be,
                        input logic [23:0] cm, input int ce, input logic cz,
                        input logic pn, input logic an, input logic [1:0] md);
    a_man = am; a_exp = EW'(ae); b_man = bm; b_exp = EW'(be);
    c_man = cm; c_exp = EW'(ce); addend_zero = cz;
    prod_neg = pn; addend_neg = an; rnd_mode = md;
  endtask

  task automatic run_op(input logic [23:0] am, input int ae, input logic [23:0] bm, input int be,
                        input logic [23:0] cm, input int ce, input logic cz,
                        input logic pn, input logic an, input logic [1:0] md);
    @(negedge clk);
    set_op(am, ae, bm, be, cm, ce, cz, pn, an, md);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [31:0] r, input logic o, input logic u, input logic x);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " result"}, out_result, r);
    chk({tag, " flags ovf/uf/inx"}, {29'd0, out_overflow, out_underflow, out_inexact}, {29'd0, o, u, x});
  endtask

  task automatic t_reset;
    chk("R2 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_product_only;
    run_op(24'hC00000, 0, 24'hC00000, 0, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R3 1.5*1.5", 32'h40100000, 0, 0, 0);
    run_op(24'hC00000, 3, 24'h800000, -1, 24'h0, 0, 1'b1, 1'b1, 1'b0, 2'd0);
    expect_res("R3 -(1.5*2^2)", 32'hC0C00000, 0, 0, 0);
  endtask

  task automatic t_same_sign;
    run_op(24'hC00000, 0, 24'hC00000, 0, 24'hE00000, 0, 1'b0, 1'b0, 1'b0, 2'd0);
    expect_res("R4 2.25+1.75 carry", 32'h40800000, 0, 0, 0);
  endtask

  task automatic t_diff_sign;
    run_op(24'hC00000, 0, 24'h800000, 0, 24'h800000, 2, 1'b0, 1'b1, 1'b0, 2'd0);
    expect_res("R5 4-1.5", 32'h40200000, 0, 0, 0);
    run_op(24'hC00000, 0, 24'h800000, 0, 24'h800000, 0, 1'b0, 1'b1, 1'b0, 2'd0);
    expect_res("R5 1-1.5 sign of larger", 32'hBF000000, 0, 0, 0);
  endtask

  task automatic t_cancel;
    run_op(24'hC00000, 0, 24'hC00000, 0, 24'h900000, 1, 1'b0, 1'b1, 1'b0, 2'd0);
    expect_res("R6 exact cancel near", 32'h00000000, 0, 0, 0);
    run_op(24'hC00000, 0, 24'hC00000, 0, 24'h900000, 1, 1'b0, 1'b1, 1'b0, 2'd3);
    expect_res("R6 exact cancel down", 32'h80000000, 0, 0, 0);
  endtask

  task automatic t_sticky_align;
    run_op(24'h800000, 0, 24'h800000, 0, 24'h800000, -40, 1'b0, 1'b0, 1'b0, 2'd0);
    expect_res("R7 tiny addend near", 32'h3F800000, 0, 0, 1);
    run_op(24'h800000, 0, 24'h800000, 0, 24'h800000, -40, 1'b0, 1'b0, 1'b0, 2'd2);
    expect_res("R7 R8 tiny addend up", 32'h3F800001, 0, 0, 1);
    run_op(24'h800000, 0, 24'h800000, 0, 24'h800000, -40, 1'b0, 1'b0, 1'b0, 2'd1);
    expect_res("R8 tiny addend toward zero", 32'h3F800000, 0, 0, 1);
    run_op(24'h800000, 0, 24'h800000, 0, 24'h800000, -40, 1'b0, 1'b1, 1'b1, 2'd3);
    expect_res("R8 negative down", 32'hBF800001, 0, 0, 1);
    run_op(24'h800000, 0, 24'h800000, -40, 24'h800000, 0, 1'b0, 1'b1, 1'b0, 2'd1);
    expect_res("R7 R5 tiny product subtract toward zero", 32'h3F7FFFFF, 0, 0, 1);
  endtask

  task automatic t_ties;
    run_op(24'h800001, 0, 24'hC00000, 0, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R8 tie to even up", 32'h3FC00002, 0, 0, 1);
    run_op(24'h800003, 0, 24'hC00000, 0, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R8 R11 tie to even stays", 32'h3FC00004, 0, 0, 1);
  endtask

  task automatic t_overflow;
    run_op(24'hC00000, 100, 24'hC00000, 100, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R9 ovf near", 32'h7F800000, 1, 0, 1);
    run_op(24'hC00000, 100, 24'hC00000, 100, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd1);
    expect_res("R9 ovf toward zero", 32'h7F7FFFFF, 1, 0, 1);
    run_op(24'hC00000, 100, 24'hC00000, 100, 24'h0, 0, 1'b1, 1'b1, 1'b0, 2'd2);
    expect_res("R9 neg ovf up", 32'hFF7FFFFF, 1, 0, 1);
    run_op(24'hC00000, 100, 24'hC00000, 100, 24'h0, 0, 1'b1, 1'b1, 1'b0, 2'd3);
    expect_res("R9 neg ovf down", 32'hFF800000, 1, 0, 1);
  endtask

  task automatic t_underflow;
    run_op(24'h800000, -100, 24'hC00000, -40, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R10 exact subnormal", 32'h00000300, 0, 0, 0);
    run_op(24'h800001, -100, 24'h800000, -40, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R10 inexact subnormal near", 32'h00000200, 0, 1, 1);
    run_op(24'h800001, -100, 24'h800000, -40, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd2);
    expect_res("R10 inexact subnormal up", 32'h00000201, 0, 1, 1);
    run_op(24'h800000, -100, 24'h800000, -100, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_res("R10 flush to zero near", 32'h00000000, 0, 1, 1);
    run_op(24'h800000, -100, 24'h800000, -100, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd2);
    expect_res("R10 R11 tiny up", 32'h00000001, 0, 1, 1);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    out_ready = 1'b0;
    set_op(24'hC00000, 0, 24'hC00000, 0, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1 valid after accept", {31'd0, out_valid}, 32'd1);
    chk("R1 ready low when stalled", {31'd0, in_ready}, 32'd0);
    set_op(24'hE00000, 0, 24'h800000, 1, 24'h0, 0, 1'b1, 1'b0, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    chk("R1 result held while stalled", out_result, 32'h40100000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second op taken after release", out_result, 32'h40600000);
    chk("R1 valid with second op", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R1 valid drops when drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_product_only;
    t_same_sign;
    t_diff_sign;
    t_cancel;
    t_sticky_align;
    t_ties;
    t_overflow;
    t_underflow;
    t_handshake;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule